// File: doc/BRIEF.md
# Linear-Address Track Scan Counter

This block counts straight, parallel tracks in a stack of bit-plane memories once their common slope is known. For every offset in a programmed range it drives one read address per plane. The address of plane `i` is the offset plus `i` times the slope. It reads one bit back from each plane and adds the hits into a correlation sum. A run of offsets whose sum reaches the threshold is one track. The track is reported when the run closes, as a record holding the offset where the sum peaked and the hit count at that peak.

The memories sit outside the block. Each is a synchronous single-bit RAM that returns data one cycle after it samples its address. The block latches the slope, threshold and scan range on a start strobe. It streams track records through a valid/ready handshake. At the end it pulses `done` with the total number of tracks found. The default geometry is 10 planes of 800 positions.

Top module: `track_scan_counter`

## Requirements
- R1: After reset, `rec_valid`, `done` and `busy` are low and no plane read enable is high.
- R2: For each offset `o`, visited once and in ascending order from `scan_first` to `scan_last` inclusive, plane `i` is read at address `o + i*slope`. The slope and the offsets are two's-complement signed values, and plane `i`'s address occupies bits `i*AW +: AW` of `rd_addr`.
- R3: A plane whose computed address falls outside `0..DEPTH-1` has its read enable low, and whatever its `rd_data` bit holds on the next cycle adds nothing to the sum.
- R4: The sum for an offset is the number of enabled planes that returned 1. A maximal run of consecutive offsets with sum ≥ threshold produces exactly one record. The record carries the earliest offset holding the run's largest sum, and that sum.
- R5: A run still open at `scan_last` is reported as a record before the scan finishes.
- R6: Records come out in ascending offset order. A record with `rec_valid` high and `rec_ready` low keeps its offset and hit count unchanged on the next cycle.
- R7: After the last record has been accepted, `done` is high for exactly one cycle. In that cycle `track_count` equals the number of records produced by the scan and `rec_valid` is low.
- R8: `start` is ignored while `busy` is high. Slope, threshold and range are taken only when a scan is accepted.
- R9: If `scan_first` is greater than `scan_last`, no plane is read, no record is produced and `done` reports a count of zero.
- R10: With a threshold of zero, the whole non-empty range forms a single run and yields one record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| slope | input | SLOPE_W | Signed address step between adjacent planes |
| thresh | input | HW | Minimum sum that counts as on a track |
| scan_first | input | OFS_W | Signed first offset of the sweep |
| scan_last | input | OFS_W | Signed last offset of the sweep, inclusive |
| busy | output | 1 | A scan is in progress |
| rd_en | output | NPLANE | Per-plane read enable |
| rd_addr | output | NPLANE*AW | Per-plane read address, plane i at bits i*AW +: AW |
| rd_data | input | NPLANE | Per-plane read bit, valid one cycle after the enable |
| rec_valid | output | 1 | A track record is offered |
| rec_ready | input | 1 | Consumer takes the record |
| rec_offset | output | OFS_W | Signed offset of the track's peak |
| rec_hits | output | HW | Hit count at the peak |
| done | output | 1 | One-cycle end-of-scan pulse |
| track_count | output | CNT_W | Tracks found in the last scan |

## Verification
On every cycle the assertions check several properties. Each enabled address lies inside the plane depth. Adjacent enabled planes differ in address by exactly the latched slope. Reads happen only during a scan. A stalled record holds still, no record falls below the threshold, and `done` is a lone pulse that never overlaps an offered record. Whether the right offsets were visited cannot be seen from a single cycle, and neither can whether runs were split correctly, whether the peak of a run was chosen, or whether a late start was ignored. The bench's sweeps show these. They cover many slopes, thresholds and images against an arithmetic model, with back-pressure on the record stream and memories that return ones on disabled planes.

// File: rtl/tsc_pkg.sv
// Shared definitions for the track scan counter.
// Assumes nothing beyond standard SystemVerilog.
package tsc_pkg;

    // Sequencer states: issue addresses, collect data, evaluate, close, drain.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_EVAL,
        ST_FIN,
        ST_DRAIN
    } scan_state_t;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tsc_addr_gen.sv
// Per-plane address generator.
// Computes offset + i*slope for every plane in a wide signed width, flags
// addresses inside 0..DEPTH-1 and drives an enable only for those.
// Assumes ofs and slope are two's-complement signed values.
module tsc_addr_gen #(
    parameter int NPLANE  = 10,
    parameter int DEPTH   = 800,
    parameter int SLOPE_W = 8,
    parameter int OFS_W   = 12,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic                      active,
    input  logic signed [OFS_W-1:0]   ofs,
    input  logic signed [SLOPE_W-1:0] slope,
    output logic [NPLANE-1:0]         en,
    output logic [NPLANE*AW-1:0]      addr
);
    localparam int EW = OFS_W + SLOPE_W + $clog2(NPLANE) + 2;
    localparam logic signed [EW-1:0] DEP = EW'(DEPTH);

    for (genvar g = 0; g < NPLANE; g++) begin : g_plane
        localparam logic signed [EW-1:0] IDX = EW'(g);
        logic signed [EW-1:0] full;
        logic                 in_rng;

        // Linear address of this plane and its range test.
        always_comb begin
            full   = EW'(ofs) + IDX * EW'(slope);
            in_rng = !full[EW-1] && (full < DEP);
        end

        assign en[g]             = active && in_rng;
        assign addr[g*AW +: AW]  = in_rng ? full[AW-1:0] : '0;
    end
endmodule

// File: rtl/tsc_hit_sum.sv
// Population count of the masked plane bits.
// Assumes HW is wide enough to hold NPLANE.
module tsc_hit_sum #(
    parameter int NPLANE = 10,
    parameter int HW     = 4
) (
    input  logic [NPLANE-1:0] bits,
    output logic [HW-1:0]     count
);
    // Add one per set bit.
    always_comb begin
        count = '0;
        for (int i = 0; i < NPLANE; i++) count = count + HW'(bits[i]);
    end
endmodule

// File: rtl/tsc_peak_track.sv
// Run and peak tracker.
// A run is a stretch of consecutive offsets with sum >= thr. It keeps the
// first offset holding the largest sum of the open run. 'ends' reports that
// the sum now presented would close an open run.
// Assumes adv and fin are never high together and clear only when idle.
module tsc_peak_track #(
    parameter int HW    = 4,
    parameter int OFS_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    adv,
    input  logic                    fin,
    input  logic [HW-1:0]           sum,
    input  logic [HW-1:0]           thr,
    input  logic signed [OFS_W-1:0] ofs,
    output logic                    run_open,
    output logic                    ends,
    output logic signed [OFS_W-1:0] best_ofs,
    output logic [HW-1:0]           best_sum
);
    assign ends = run_open && (sum < thr);

    // Open, extend or close the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_open <= 1'b0;
            best_ofs <= '0;
            best_sum <= '0;
        end else if (adv) begin
            if (sum >= thr) begin
                if (!run_open || sum > best_sum) begin
                    best_ofs <= ofs;
                    best_sum <= sum;
                end
                run_open <= 1'b1;
            end else begin
                run_open <= 1'b0;
            end
        end else if (fin) begin
            run_open <= 1'b0;
        end
    end
endmodule

// File: rtl/track_scan_counter.sv
// Linear-address track scan counter (top).
// Sweeps an offset over [scan_first, scan_last]. For each offset it reads one
// bit per plane at offset + i*slope, sums the hits and emits one record per
// run of sums at or above the threshold. It finishes with a done pulse that
// carries the number of tracks.
// Assumes synchronous plane RAMs with one cycle of read latency.
module track_scan_counter
    import tsc_pkg::*;
#(
    parameter int NPLANE  = 10,
    parameter int DEPTH   = 800,
    parameter int SLOPE_W = 8,
    parameter int OFS_W   = 12,
    parameter int CNT_W   = 10,
    localparam int AW     = $clog2(DEPTH),
    localparam int HW     = count_bits(NPLANE)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic signed [SLOPE_W-1:0] slope,
    input  logic [HW-1:0]             thresh,
    input  logic signed [OFS_W-1:0]   scan_first,
    input  logic signed [OFS_W-1:0]   scan_last,
    output logic                      busy,
    output logic [NPLANE-1:0]         rd_en,
    output logic [NPLANE*AW-1:0]      rd_addr,
    input  logic [NPLANE-1:0]         rd_data,
    output logic                      rec_valid,
    input  logic                      rec_ready,
    output logic signed [OFS_W-1:0]   rec_offset,
    output logic [HW-1:0]             rec_hits,
    output logic                      done,
    output logic [CNT_W-1:0]          track_count
);
    scan_state_t               state;
    logic signed [OFS_W-1:0]   ofs, last_q;
    logic signed [SLOPE_W-1:0] slope_q;
    logic [HW-1:0]             thr_q, sum_q, hit_now;
    logic [NPLANE-1:0]         en_q;
    logic                      run_open, ends, slot_free;
    logic                      go_eval, go_fin, emit, clear;
    logic signed [OFS_W-1:0]   best_ofs;
    logic [HW-1:0]             best_sum;

    tsc_addr_gen #(
        .NPLANE(NPLANE), .DEPTH(DEPTH), .SLOPE_W(SLOPE_W), .OFS_W(OFS_W)
    ) u_addr (
        .active(state == ST_ADDR), .ofs(ofs), .slope(slope_q),
        .en(rd_en), .addr(rd_addr)
    );

    tsc_hit_sum #(.NPLANE(NPLANE), .HW(HW)) u_sum (
        .bits(rd_data & en_q), .count(hit_now)
    );

    tsc_peak_track #(.HW(HW), .OFS_W(OFS_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .clear(clear), .adv(go_eval), .fin(go_fin),
        .sum(sum_q), .thr(thr_q), .ofs(ofs),
        .run_open(run_open), .ends(ends), .best_ofs(best_ofs), .best_sum(best_sum)
    );

    // Step control: stall only when a record must leave and the slot is full.
    always_comb begin
        slot_free = !rec_valid || rec_ready;
        clear     = (state == ST_IDLE) && start;
        go_eval   = (state == ST_EVAL) && (slot_free || !ends);
        go_fin    = (state == ST_FIN) && (slot_free || !run_open);
        emit      = (go_eval && ends) || (go_fin && run_open);
        busy      = (state != ST_IDLE);
    end

    // Scan sequencer: offset walk, read pipeline and end-of-scan pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ofs     <= '0;
            last_q  <= '0;
            slope_q <= '0;
            thr_q   <= '0;
            en_q    <= '0;
            sum_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    slope_q <= slope;
                    thr_q   <= thresh;
                    last_q  <= scan_last;
                    ofs     <= scan_first;
                    state   <= (scan_first > scan_last) ? ST_FIN : ST_ADDR;
                end
                ST_ADDR: begin
                    en_q  <= rd_en;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    sum_q <= hit_now;
                    state <= ST_EVAL;
                end
                ST_EVAL: if (go_eval) begin
                    if (ofs == last_q) begin
                        state <= ST_FIN;
                    end else begin
                        ofs   <= ofs + OFS_W'(1);
                        state <= ST_ADDR;
                    end
                end
                ST_FIN: if (go_fin) state <= ST_DRAIN;
                ST_DRAIN: if (!rec_valid) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Record slot and track counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid   <= 1'b0;
            rec_offset  <= '0;
            rec_hits    <= '0;
            track_count <= '0;
        end else begin
            if (clear) track_count <= '0;
            if (emit) begin
                rec_valid   <= 1'b1;
                rec_offset  <= best_ofs;
                rec_hits    <= best_sum;
                track_count <= track_count + CNT_W'(1);
            end else if (rec_ready) begin
                rec_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tsc_checker.sv
// Cycle-level properties of the track scan counter, bound to the top.
// Assumes the bound instance exposes its latched slope and threshold.
module tsc_checker #(
    parameter int NPLANE  = 10,
    parameter int DEPTH   = 800,
    parameter int SLOPE_W = 8,
    parameter int OFS_W   = 12,
    parameter int HW      = 4,
    localparam int AW     = $clog2(DEPTH)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy,
    input logic [NPLANE-1:0]         rd_en,
    input logic [NPLANE*AW-1:0]      rd_addr,
    input logic signed [SLOPE_W-1:0] slope_q,
    input logic [HW-1:0]             thr_q,
    input logic                      rec_valid,
    input logic                      rec_ready,
    input logic signed [OFS_W-1:0]   rec_offset,
    input logic [HW-1:0]             rec_hits,
    input logic                      done
);
    for (genvar g = 0; g < NPLANE; g++) begin : g_rng
        p_addr_in_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[g] |-> (int'(rd_addr[g*AW +: AW]) < DEPTH));
    end

    for (genvar g = 1; g < NPLANE; g++) begin : g_step
        p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[g] && rd_en[g-1]) |->
            (AW'(rd_addr[g*AW +: AW] - rd_addr[(g-1)*AW +: AW]) == AW'(slope_q)));
    end

    p_read_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_en) |-> busy);

    p_rec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=>
        (rec_valid && $stable(rec_offset) && $stable(rec_hits)));

    p_rec_above_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_hits >= thr_q));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rec_valid);
endmodule

bind track_scan_counter tsc_checker #(
    .NPLANE(NPLANE), .DEPTH(DEPTH), .SLOPE_W(SLOPE_W), .OFS_W(OFS_W), .HW(HW)
) u_tsc_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .slope_q(slope_q), .thr_q(thr_q), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_offset(rec_offset), .rec_hits(rec_hits),
    .done(done)
);

// File: tb/track_scan_counter_bench.sv
// Sweeps slopes, thresholds, images and back-pressure on a 4x16 configuration
// and compares every record and count with an arithmetic model.
module track_scan_counter_bench;
    localparam int NP = 4, DEP = 16, SW = 4, OW = 6, CW = 8;
    localparam int AW = $clog2(DEP), HW = $clog2(NP + 1);

    logic                 clk = 1'b0, rst_n = 1'b0, start = 1'b0, rec_ready = 1'b0;
    logic signed [SW-1:0] slope_in = '0;
    logic [HW-1:0]        thr_in = '0;
    logic signed [OW-1:0] first_in = '0, last_in = '0;
    logic                 busy, rec_valid, done;
    logic [NP-1:0]        rd_en, rd_data;
    logic [NP*AW-1:0]     rd_addr;
    logic signed [OW-1:0] rec_offset;
    logic [HW-1:0]        rec_hits;
    logic [CW-1:0]        track_count;

    logic [DEP-1:0] img [NP];
    int exp_ofs [64], exp_hits [64], exp_n;
    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    track_scan_counter #(.NPLANE(NP), .DEPTH(DEP), .SLOPE_W(SW), .OFS_W(OW), .CNT_W(CW))
    u_track_scan_counter (
        .clk(clk), .rst_n(rst_n), .start(start), .slope(slope_in), .thresh(thr_in),
        .scan_first(first_in), .scan_last(last_in), .busy(busy), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_offset(rec_offset), .rec_hits(rec_hits),
        .done(done), .track_count(track_count)
    );

    // Plane RAMs with one cycle of latency; disabled planes return 1 (R3 bait).
    always_ff @(posedge clk)
        for (int p = 0; p < NP; p++)
            rd_data[p] <= rd_en[p] ? img[p][rd_addr[p*AW +: AW]] : 1'b1;

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL R7 watchdog: cycles=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int ref_sum(input int o, input int s);
        int v = 0;
        for (int p = 0; p < NP; p++) begin
            int a = o + p * s;
            if (a >= 0 && a < DEP && img[p][a]) v++;
        end
        return v;
    endfunction

    task automatic build_expect(input int f, input int l, input int s, input int thr);
        bit open = 0;
        int bo = 0, bv = 0;
        exp_n = 0;
        for (int o = f; o <= l; o++) begin
            int v = ref_sum(o, s);
            if (v >= thr) begin
                if (!open || v > bv) begin bo = o; bv = v; end
                open = 1;
            end else if (open) begin
                exp_ofs[exp_n] = bo; exp_hits[exp_n] = bv; exp_n++; open = 0;
            end
        end
        if (open) begin exp_ofs[exp_n] = bo; exp_hits[exp_n] = bv; exp_n++; end
    endtask

    task automatic make_img(input int seed, input int s);
        for (int p = 0; p < NP; p++)
            for (int a = 0; a < DEP; a++)
                img[p][a] = ((a * 5 + p * 3 + seed * 7) % 11 == 0);
        for (int p = 0; p < NP; p++) begin
            int a1 = 2 + seed + p * s, a2 = 9 + p * s;
            if (a1 >= 0 && a1 < DEP) img[p][a1] = 1'b1;
            if (a2 >= 0 && a2 < DEP) img[p][a2] = 1'b1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; rec_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One scan: start, collect records under a ready pattern, check done.
    task automatic run_scan(input int f, input int l, input int s, input int thr,
                            input int mode, input bit disturb, input string tag);
        int got = 0, last_o = -1000;
        bit fin = 0;
        build_expect(f, l, s, thr);
        slope_in = SW'(s); thr_in = HW'(thr);
        first_in = OW'(f); last_in = OW'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3000 && !fin; k++) begin
            if (disturb) begin
                start    = (k == 6);
                slope_in = (k == 6) ? SW'(-s) : SW'(s);
                first_in = (k == 6) ? OW'(l) : OW'(f);
                thr_in   = (k == 6) ? HW'(0) : HW'(thr);
            end
            case (mode)
                0: rec_ready = 1'b1;
                1: rec_ready = (k % 3 != 0);
                default: rec_ready = (k % 5 < 2);
            endcase
            if (done) begin
                check(got == exp_n, {tag, " R7 records at done"}, got, exp_n);
                check(int'(track_count) == exp_n, {tag, " R7 track_count"},
                      int'(track_count), exp_n);
                fin = 1;
            end else if (rec_valid && rec_ready) begin
                int ro = int'(rec_offset), rh = int'(rec_hits);
                if (got < exp_n) begin
                    check(ro == exp_ofs[got], {tag, " R2 R4 peak offset"}, ro, exp_ofs[got]);
                    check(rh == exp_hits[got], {tag, " R4 peak hits"}, rh, exp_hits[got]);
                end else begin
                    check(0, {tag, " R4 extra record"}, got + 1, exp_n);
                end
                check(ro > last_o, {tag, " R6 ascending"}, ro, last_o + 1);
                last_o = ro;
                got++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!fin) begin
            check(0, {tag, " R7 done missing"}, got, exp_n);
            do_reset();
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) img[p] = '0;
        do_reset();
        // R1: reset state.
        check(!rec_valid, "R1 rec_valid", int'(rec_valid), 0);
        check(!done, "R1 done", int'(done), 0);
        check(!busy, "R1 busy", int'(busy), 0);
        check(rd_en == '0, "R1 rd_en", int'(rd_en), 0);

        // R9: empty range.
        run_scan(5, 2, 1, 1, 0, 0, "R9");

        // R5: a run open at the last offset.
        for (int p = 0; p < NP; p++) img[p] = '0;
        for (int p = 0; p < NP; p++) img[p][DEP-1] = 1'b1;
        run_scan(0, DEP - 1, 0, 2, 0, 0, "R5");
        check(exp_n == 1 && exp_ofs[0] == DEP - 1, "R5 model", exp_ofs[0], DEP - 1);

        // R3: all-ones image, many planes out of range.
        for (int p = 0; p < NP; p++) img[p] = '1;
        run_scan(-10, 20, 3, 1, 1, 0, "R3");
        run_scan(-10, 20, -3, 3, 2, 0, "R3");

        // R10: threshold zero gives one run.
        make_img(1, 1);
        run_scan(0, 10, 1, 0, 1, 0, "R10");
        check(exp_n == 1, "R10 model", exp_n, 1);

        // R8: start pulse with other settings mid-scan is ignored.
        make_img(2, 2);
        run_scan(-4, 18, 2, 2, 1, 1, "R8");

        // Sweep: images x slopes x thresholds x ready patterns.
        for (int seed = 0; seed < 4; seed++)
            for (int s = -3; s <= 3; s++) begin
                make_img(seed, s);
                for (int thr = 1; thr <= NP; thr++)
                    run_scan(-6, 18, s, thr, (seed + thr) % 3, 0, "sweep");
            end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule